// File: doc/BRIEF.md
# Core Window Switch Controller

This block points a host-side address window at one of several on-chip cores. A request names a target core. If that core is not mapped at the moment, the block writes the window register with the core's window address. It then reads the register back and decodes which core the hardware really mapped. When the decoded index differs from the target, it repeats the write and read-back until an attempt budget runs out. It ends every request with a one-cycle done pulse or a one-cycle fail pulse.

The block also keeps the index of the core that is mapped now. A request for that core completes in the next cycle and causes no window traffic. A request can also carry a single-beat data access (read or write, offset and data). The block sends such an access to the downstream bus only once the window points at the right core. If the switch fails, the access is dropped. Only one request is handled at a time. `busy` covers the cycles in which the window is being changed.

Top module: `core_window_switch`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `mapped_valid`, `win_wr_en`, `win_rd_en` and `bus_valid` are all low.
- R2: Every window write carries the value `WIN_BASE + (core << SPAN_LOG2)`, where core is the target index (default span 4 KiB, so shift 12).
- R3: Each window write is followed in the next cycle by a one-cycle window read. The read data returns one cycle after the read strobe. The block decodes it as `(data - WIN_BASE) >> SPAN_LOG2`. When the result equals the target, `done` rises three cycles after the write strobe.
- R4: When the decoded index differs from the target, the block issues another write three cycles after the previous one, as long as attempts remain. A switch that matches on a later attempt still ends with `done`.
- R5: A switch makes at most `MAX_RETRY + 1` window writes (default 11). If every read-back mismatches, `fail` is high for exactly one cycle, three cycles after the last write strobe. `mapped_core` and `mapped_valid` keep their values.
- R6: When a switch succeeds, `mapped_core` shows the target and `mapped_valid` is high in the same cycle as `done`.
- R7: A request for the core already mapped (with `mapped_valid` high) gives `done` in the cycle after the request and no window write or read.
- R8: `busy` is high from the cycle after a switching request is accepted until the cycle before `done` or `fail`. While `busy` is high, requests are ignored.
- R9: A data access (`req_access`=1) to the mapped core sets `bus_valid` in the cycle after the request, together with `done`. It carries the requested `bus_we`, `bus_addr` and `bus_wdata`.
- R10: A data access to another core is issued on the bus, with `done`, only after its switch succeeds. If the switch fails, `fail` pulses and `bus_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_core | input | IDX_W | Target core index |
| req_access | input | 1 | 1: request carries a data access |
| req_we | input | 1 | Access direction, 1 = write |
| req_addr | input | OFS_W | Access offset inside the window |
| req_wdata | input | DATA_W | Access write data |
| busy | output | 1 | Window change in progress |
| done | output | 1 | Request completed successfully (pulse) |
| fail | output | 1 | Switch gave up (pulse) |
| mapped_core | output | IDX_W | Core currently mapped |
| mapped_valid | output | 1 | mapped_core is meaningful |
| win_wr_en | output | 1 | Window register write strobe |
| win_wr_data | output | ADDR_W | Window register write value |
| win_rd_en | output | 1 | Window register read strobe |
| win_rd_data | input | ADDR_W | Window register read value, one cycle after win_rd_en |
| bus_valid | output | 1 | Single-beat access issued (pulse) |
| bus_we | output | 1 | Issued access direction |
| bus_addr | output | OFS_W | Issued access offset |
| bus_wdata | output | DATA_W | Issued access write data |

## Verification
A wrong mapped-core register shows up at the next request. A request that should hit would cause window writes, or one that should switch would answer in one cycle. In both cases the `busy` and `done` timing differs from the model within two cycles. A retry counter that is off by one moves the `fail` pulse by three cycles, or turns an expected fail into a done. That is visible when the read-back is corrupted exactly up to the retry limit. An encode or decode error either changes `win_wr_data` in the first write cycle or forces retries that a correct block would not make.

// File: rtl/cws_pkg.sv
package cws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_CHECK = 2'd3
  } cws_state_e;
endpackage

// File: rtl/cws_window_codec.sv
module cws_window_codec #(
  parameter int          IDX_W     = 4,
  parameter int          ADDR_W    = 32,
  parameter int          SPAN_LOG2 = 12,
  parameter logic [31:0] WIN_BASE  = 32'h1800_0000
) (
  input  logic [IDX_W-1:0]  core_idx,
  input  logic [ADDR_W-1:0] readback,
  output logic [ADDR_W-1:0] win_value,
  output logic              idx_match
);
  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(WIN_BASE);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] decoded;

  always_comb begin
    win_value = BASE_W + (ADDR_W'(core_idx) << SPAN_LOG2);
    offset    = readback - BASE_W;
    decoded   = offset >> SPAN_LOG2;
    idx_match = (decoded == ADDR_W'(core_idx));
  end
endmodule

// File: rtl/cws_retry_ctr.sv
module cws_retry_ctr #(
  parameter int MAX_RETRY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic exhausted
);
  localparam int CNT_W = $clog2(MAX_RETRY + 2);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (bump)    count <= count + 1'b1;
  end

  assign exhausted = (count == CNT_W'(MAX_RETRY));

  // R5: the number of retries never goes past the limit
  assert_retry_bound_R5: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(MAX_RETRY));
endmodule

// File: rtl/core_window_switch.sv
module core_window_switch #(
  parameter int          IDX_W     = 4,
  parameter int          ADDR_W    = 32,
  parameter int          SPAN_LOG2 = 12,
  parameter logic [31:0] WIN_BASE  = 32'h1800_0000,
  parameter int          MAX_RETRY = 10,
  parameter int          OFS_W     = 12,
  parameter int          DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_core,
  input  logic              req_access,
  input  logic              req_we,
  input  logic [OFS_W-1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [IDX_W-1:0]  mapped_core,
  output logic              mapped_valid,
  output logic              win_wr_en,
  output logic [ADDR_W-1:0] win_wr_data,
  output logic              win_rd_en,
  input  logic [ADDR_W-1:0] win_rd_data,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [OFS_W-1:0]  bus_addr,
  output logic [DATA_W-1:0] bus_wdata
);
  import cws_pkg::*;

  cws_state_e        state;
  logic [IDX_W-1:0]  tgt_core;
  logic              tgt_access, tgt_we;
  logic [OFS_W-1:0]  tgt_addr;
  logic [DATA_W-1:0] tgt_wdata;

  logic [IDX_W-1:0]  codec_idx;
  logic [ADDR_W-1:0] enc_value;
  logic              rb_match;
  logic              hit, accept, retry_clear, retry_bump, retry_out;

  assign codec_idx   = (state == ST_IDLE) ? req_core : tgt_core;
  assign accept      = (state == ST_IDLE) && req_valid;
  assign hit         = mapped_valid && (req_core == mapped_core);
  assign retry_clear = accept;
  assign retry_bump  = (state == ST_CHECK) && !rb_match && !retry_out;

  cws_window_codec #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2), .WIN_BASE(WIN_BASE)
  ) u_codec (
    .core_idx (codec_idx),
    .readback (win_rd_data),
    .win_value(enc_value),
    .idx_match(rb_match)
  );

  cws_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk      (clk),
    .rst      (rst),
    .clear    (retry_clear),
    .bump     (retry_bump),
    .exhausted(retry_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      busy         <= 1'b0;
      done         <= 1'b0;
      fail         <= 1'b0;
      mapped_core  <= '0;
      mapped_valid <= 1'b0;
      win_wr_en    <= 1'b0;
      win_wr_data  <= '0;
      win_rd_en    <= 1'b0;
      bus_valid    <= 1'b0;
      bus_we       <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      tgt_core     <= '0;
      tgt_access   <= 1'b0;
      tgt_we       <= 1'b0;
      tgt_addr     <= '0;
      tgt_wdata    <= '0;
    end else begin
      done      <= 1'b0;
      fail      <= 1'b0;
      bus_valid <= 1'b0;
      win_wr_en <= 1'b0;
      win_rd_en <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            tgt_core   <= req_core;
            tgt_access <= req_access;
            tgt_we     <= req_we;
            tgt_addr   <= req_addr;
            tgt_wdata  <= req_wdata;
            if (hit) begin
              done      <= 1'b1;
              bus_valid <= req_access;
              bus_we    <= req_we;
              bus_addr  <= req_addr;
              bus_wdata <= req_wdata;
            end else begin
              busy        <= 1'b1;
              win_wr_en   <= 1'b1;
              win_wr_data <= enc_value;
              state       <= ST_READ;
            end
          end
        end
        ST_READ: begin
          win_rd_en <= 1'b1;
          state     <= ST_WAIT;
        end
        ST_WAIT: state <= ST_CHECK;
        ST_CHECK: begin
          if (rb_match) begin
            busy         <= 1'b0;
            done         <= 1'b1;
            mapped_core  <= tgt_core;
            mapped_valid <= 1'b1;
            bus_valid    <= tgt_access;
            bus_we       <= tgt_we;
            bus_addr     <= tgt_addr;
            bus_wdata    <= tgt_wdata;
            state        <= ST_IDLE;
          end else if (retry_out) begin
            busy  <= 1'b0;
            fail  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            win_wr_en   <= 1'b1;
            win_wr_data <= enc_value;
            state       <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a strobe never writes and reads in the same cycle; every write is read back next
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(win_wr_en && win_rd_en));
  assert_read_follows_write_R3: assert property (@(posedge clk) disable iff (rst)
    win_wr_en |=> win_rd_en);
  // R5: outcomes exclusive, mapping kept on failure
  assert_done_fail_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  assert_fail_keeps_map_R5: assert property (@(posedge clk) disable iff (rst)
    fail |-> ($stable(mapped_core) && $stable(mapped_valid)));
  // R6: success leaves a valid mapping
  assert_done_mapped_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> mapped_valid);
  // R8: busy ends exactly with an outcome
  assert_busy_ends_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || fail));
  assert_outcome_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> !busy);
  // R9: a bus access is only ever issued on a successful completion
  assert_bus_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> done);
endmodule

// File: tb/core_window_switch_test.sv
module core_window_switch_test;
  localparam int          IDX_W     = 4;
  localparam int          ADDR_W    = 32;
  localparam int          SPAN_LOG2 = 12;
  localparam logic [31:0] WIN_BASE  = 32'h1800_0000;
  localparam int          MAX_RETRY = 10;
  localparam int          OFS_W     = 12;
  localparam int          DATA_W    = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              req_valid = 1'b0;
  logic [IDX_W-1:0]  req_core = '0;
  logic              req_access = 1'b0, req_we = 1'b0;
  logic [OFS_W-1:0]  req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic busy, done, fail, mapped_valid, win_wr_en, win_rd_en, bus_valid, bus_we;
  logic [IDX_W-1:0]  mapped_core;
  logic [ADDR_W-1:0] win_wr_data;
  logic [ADDR_W-1:0] win_rd_data;
  logic [OFS_W-1:0]  bus_addr;
  logic [DATA_W-1:0] bus_wdata;

  core_window_switch #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2), .WIN_BASE(WIN_BASE),
    .MAX_RETRY(MAX_RETRY), .OFS_W(OFS_W), .DATA_W(DATA_W)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_core(req_core),
    .req_access(req_access), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .fail(fail),
    .mapped_core(mapped_core), .mapped_valid(mapped_valid),
    .win_wr_en(win_wr_en), .win_wr_data(win_wr_data), .win_rd_en(win_rd_en),
    .win_rd_data(win_rd_data), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  // Window register model: the first bad_n writes of a request land on a wrong core
  integer            bad_n = 0;
  integer            wr_seen = 0;
  logic [ADDR_W-1:0] win_q = '0;
  always @(posedge clk) begin
    if (req_valid && !busy) wr_seen <= 0;
    if (win_wr_en) begin
      win_q   <= (wr_seen < bad_n) ? (win_wr_data ^ (ADDR_W'(1) << SPAN_LOG2)) : win_wr_data;
      wr_seen <= wr_seen + 1;
    end
    if (win_rd_en) win_rd_data <= win_q;
  end

  integer vectors = 0;
  integer errors  = 0;
  bit     finished = 1'b0;
  integer m_core  = 0;
  bit     m_valid = 1'b0;

  task automatic chk(input string what, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] win_of(input integer c);
    return WIN_BASE + (ADDR_W'(c) << SPAN_LOG2);
  endfunction

  // One request; expected timeline built from the requirements, compared every cycle
  task automatic run_req(input integer core, input bit acc, input bit we,
                         input logic [OFS_W-1:0] addr, input logic [DATA_W-1:0] wd,
                         input integer nbad, input bit nag);
    bit     is_hit, ok;
    integer writes, fin;
    is_hit = m_valid && (m_core == core);
    ok     = (nbad <= MAX_RETRY);
    writes = ok ? nbad + 1 : MAX_RETRY + 1;
    fin    = is_hit ? 1 : 3 * writes + 1;
    bad_n  = nbad;
    @(negedge clk);
    req_valid = 1'b1; req_core = IDX_W'(core); req_access = acc;
    req_we = we; req_addr = addr; req_wdata = wd;
    for (int k = 1; k <= fin; k++) begin
      @(negedge clk);
      if (nag && k < fin) begin
        req_core = IDX_W'((core + 7) % 16); req_access = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      if (is_hit) begin
        chk("hit done", "R7", 64'(done), 64'd1);
        chk("hit no write", "R7", 64'(win_wr_en), 64'd0);
        chk("hit busy", "R7", 64'(busy), 64'd0);
      end else begin
        chk("busy", "R8", 64'(busy), 64'(k < fin));
        chk("write strobe", "R4", 64'(win_wr_en), 64'(k < fin && k % 3 == 1));
        chk("read strobe", "R3", 64'(win_rd_en), 64'(k < fin && k % 3 == 2));
        if (win_wr_en) chk("write value", "R2", 64'(win_wr_data), 64'(win_of(core)));
        chk("done", "R3", 64'(done), 64'(k == fin && ok));
        chk("fail", "R5", 64'(fail), 64'(k == fin && !ok));
      end
      chk("bus issue", acc ? (is_hit ? "R9" : "R10") : "R9", 64'(bus_valid),
          64'(k == fin && acc && (is_hit || ok)));
      if (bus_valid) begin
        chk("bus we", "R9", 64'(bus_we), 64'(we));
        chk("bus addr", "R9", 64'(bus_addr), 64'(addr));
        chk("bus wdata", "R9", 64'(bus_wdata), 64'(wd));
      end
      if (k == fin && ok) begin
        chk("mapped core", "R6", 64'(mapped_core), 64'(core));
        chk("mapped valid", "R6", 64'(mapped_valid), 64'd1);
      end else begin
        chk("map kept core", "R5", 64'(mapped_core), 64'(m_core));
        chk("map kept valid", "R5", 64'(mapped_valid), 64'(m_valid));
      end
    end
    if (ok) begin m_core = core; m_valid = 1'b1; end
    @(negedge clk);
    chk("quiet after", "R8", 64'({done, fail, busy, win_wr_en}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("busy", "R1", 64'(busy), 64'd0);
    chk("done/fail", "R1", 64'({done, fail}), 64'd0);
    chk("mapped valid", "R1", 64'(mapped_valid), 64'd0);
    chk("strobes", "R1", 64'({win_wr_en, win_rd_en, bus_valid}), 64'd0);
    rst = 1'b0;
    run_req(3, 0, 0, 12'h000, 32'h0, 0, 0);          // plain switch
    run_req(3, 0, 0, 12'h000, 32'h0, 0, 0);          // hit
    run_req(3, 1, 0, 12'h1a4, 32'h0, 0, 0);          // access to mapped core
    run_req(5, 0, 0, 12'h000, 32'h0, 2, 1);          // retries, nagging while busy
    run_req(9, 0, 0, 12'h000, 32'h0, 11, 0);         // fail, map kept
    run_req(9, 1, 1, 12'h7fc, 32'hdead_beef, 0, 0);  // access needs switch (R10)
    run_req(2, 1, 1, 12'h010, 32'h1234_5678, 11, 0); // access abandoned (R10)
    run_req(15, 0, 0, 12'h000, 32'h0, 10, 0);        // match on final attempt (R4)
    run_req(0, 1, 1, 12'hffc, 32'hcafe_f00d, 1, 0);
    run_req(0, 1, 0, 12'h004, 32'h0, 0, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule